// File: doc/BRIEF.md
# Dual-Port MDIO Management Frame Engine

This block produces clause-22 management frames toward a PHY over one of two physically separate management ports, called internal and external. Each port has its own clock, data-out, output-enable and data-in line. A short probe chooses which port is used. The probe raises both port-enable outputs, waits a fixed number of cycles, and then reads back which sense input stayed set. If the external one stayed, the external port is chosen. Otherwise, if the internal one stayed, the internal port is chosen. If neither stayed, the block raises an error flag.

A client issues a read or write over a valid/ready handshake. The request carries a 5-bit register number and, for writes, 16 data bits. The engine first sends a preamble of clock pulses with the data line released high. It then clocks the frame out on the chosen port, using that port's fixed PHY address. For a read, the 16 captured bits are returned together with a one-cycle done pulse.

The two ports sample read data at different points in the bit. The external port samples just before the clock's rising edge. The internal port samples late in the high phase.

Top module: `mdio_dual_eng`

## Requirements
- R1: After reset the following hold: `req_ready_o` is 1, `port_sel_o` is 0, `det_err_o` is 0, `done_o` is 0, both management clocks and both output enables are 0, and both data outputs are 1.
- R2: `port_sel_o` uses the encoding 0 for no port, 1 for internal and 2 for external. A probe raises both `port_en_*_o` for SETTLE_CYC cycles. It then selects external if `sense_ext_i` is high, otherwise internal if `sense_int_i` is high. If neither is high, it selects no port and sets `det_err_o`.
- R3: Every frame begins with PRE_LEN clock pulses during which the output enable is 0 and the data output is 1.
- R4: A write sends 32 driven bits, MSB first, in this order: start 0,1; op 0,1; the 5-bit PHY address; the 5-bit register; turnaround 1,0; the 16 data bits. The output enable is 1 for all 32 bits.
- R5: A read sends start 0,1, op 1,0, the PHY address and the register, for 14 driven bits. It then releases the line (output enable 0, data 1) for 21 more clocks: 2 turnaround, 16 data and 3 trailing.
- R6: On the external port, read bit k is the value on `mdi_ext_i` in the last low-phase cycle of post-preamble bit 16+k. It is packed MSB first.
- R7: On the internal port, read bit k is the value on `mdi_int_i` in the last high-phase cycle of post-preamble bit 16+k.
- R8: The address field carries PHY_ADDR_INT on the internal port and PHY_ADDR_EXT on the external port.
- R9: Each bit is HALF_CYC cycles with the clock low and then HALF_CYC cycles with the clock high. `done_o` is high for one cycle, exactly bits×2×HALF_CYC cycles after the accepting edge, with `err_o` low.
- R10: `req_ready_o` is 0 while a frame or a probe is in progress. A request held valid during that time is accepted afterwards and executed in full.
- R11: A request accepted while no port is selected gives `done_o` and `err_o` on the next cycle, and neither management clock toggles.
- R12: The port that is not selected stays idle: clock 0, output enable 0, data 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_start_i | input | 1 | Starts a port probe; honoured only when no frame is running |
| det_busy_o | output | 1 | Probe in progress |
| port_sel_o | output | 2 | Selected port: 0 none, 1 internal, 2 external |
| det_err_o | output | 1 | Last probe found no port |
| port_en_int_o | output | 1 | Internal port-enable bit raised during the probe |
| port_en_ext_o | output | 1 | External port-enable bit raised during the probe |
| sense_int_i | input | 1 | Internal enable bit read back |
| sense_ext_i | input | 1 | External enable bit read back |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_reg_i | input | 5 | Register number |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion was an error (valid with done_o) |
| rdata_o | output | 16 | Read data (valid with done_o) |
| mdc_int_o | output | 1 | Internal management clock |
| mdo_int_o | output | 1 | Internal data out |
| mdoe_int_o | output | 1 | Internal output enable |
| mdi_int_i | input | 1 | Internal data in |
| mdc_ext_o | output | 1 | External management clock |
| mdo_ext_o | output | 1 | External data out |
| mdoe_ext_o | output | 1 | External output enable |
| mdi_ext_i | input | 1 | External data in |

## Verification
The bench builds the engine with these parameters:
- PRE_LEN of 4, so frames are short enough to sweep every one of the 32 register numbers as both a write and a read on each port.
- HALF_CYC of 2, so the low-phase and high-phase sample points fall in different cycles.
- SETTLE_CYC of 3.
- Distinct PHY addresses 5'h05 and 5'h1A, so a swapped address is visible.

The bench acts as the PHY and advances its read data on every clock rise. As a result, the two ports' sample points return read values offset by one bit, and each value can be predicted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        PSEL_NONE = 2'd0,
        PSEL_INT  = 2'd1,
        PSEL_EXT  = 2'd2
    } psel_e;

    localparam int FRAME_W = 32;
    localparam int DATA_W  = 16;
    localparam int REG_W   = 5;

    // Driven part of a clause-22 frame, first bit in the MSB.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic              wr,
        input logic [REG_W-1:0]  phy,
        input logic [REG_W-1:0]  regn,
        input logic [DATA_W-1:0] data
    );
        logic [1:0]        op;
        logic [DATA_W-1:0] payload;
        op      = wr ? 2'b01 : 2'b10;
        payload = wr ? data : '0;
        return {2'b01, op, phy, regn, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic phase_o,
    output logic end_low_o,
    output logic end_high_o
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } tmr_t;

    tmr_t tmr_q, tmr_d;
    logic wrap;

    assign wrap = (tmr_q.cnt == CNT_W'(HALF_CYC - 1));

    always_comb begin
        tmr_d = tmr_q;
        if (!en_i) begin
            tmr_d.cnt   = '0;
            tmr_d.phase = 1'b0;
        end else if (wrap) begin
            tmr_d.cnt   = '0;
            tmr_d.phase = ~tmr_q.phase;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt   <= '0;
            tmr_q.phase <= 1'b0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign phase_o    = tmr_q.phase;
    assign end_low_o  = en_i & ~tmr_q.phase & wrap;
    assign end_high_o = en_i & tmr_q.phase & wrap;

    // R9: the end of a high phase is followed by a low phase
    assert_high_then_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        end_high_o |=> !phase_o);
    // R9: the end of a low phase is followed by a high phase
    assert_low_then_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        end_low_o |=> phase_o);

endmodule

// File: rtl/mdio_port_detect.sv
module mdio_port_detect #(
    parameter int SETTLE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            allow_i,
    input  logic            sense_int_i,
    input  logic            sense_ext_i,
    output logic            en_int_o,
    output logic            en_ext_o,
    output logic            busy_o,
    output mdio_pkg::psel_e sel_o,
    output logic            err_o
);
    import mdio_pkg::*;

    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    typedef struct packed {
        logic          probe;
        logic [CW-1:0] cnt;
        psel_e         sel;
        logic          err;
    } det_t;

    det_t det_q, det_d;

    always_comb begin
        det_d = det_q;
        if (det_q.probe) begin
            if (det_q.cnt == CW'(SETTLE_CYC - 1)) begin
                det_d.probe = 1'b0;
                det_d.cnt   = '0;
                if (sense_ext_i) begin
                    det_d.sel = PSEL_EXT;
                    det_d.err = 1'b0;
                end else if (sense_int_i) begin
                    det_d.sel = PSEL_INT;
                    det_d.err = 1'b0;
                end else begin
                    det_d.sel = PSEL_NONE;
                    det_d.err = 1'b1;
                end
            end else begin
                det_d.cnt = det_q.cnt + 1'b1;
            end
        end else if (start_i && allow_i) begin
            det_d.probe = 1'b1;
            det_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q.probe <= 1'b0;
            det_q.cnt   <= '0;
            det_q.sel   <= PSEL_NONE;
            det_q.err   <= 1'b0;
        end else begin
            det_q <= det_d;
        end
    end

    assign en_int_o = det_q.probe;
    assign en_ext_o = det_q.probe;
    assign busy_o   = det_q.probe;
    assign sel_o    = det_q.sel;
    assign err_o    = det_q.err;

    // R2: a finished probe ends with either a port or the error flag, never both
    assert_probe_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ((sel_o != PSEL_NONE) != err_o));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
    parameter int         PRE_LEN      = 32,
    parameter int         HALF_CYC     = 4,
    parameter logic [4:0] PHY_ADDR_INT = 5'h01,
    parameter logic [4:0] PHY_ADDR_EXT = 5'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic            req_write_i,
    input  logic [4:0]      req_reg_i,
    input  logic [15:0]     req_wdata_i,
    input  logic            block_i,
    input  mdio_pkg::psel_e sel_i,
    input  logic            mdi_i,
    output logic            req_ready_o,
    output logic            busy_o,
    output logic            use_ext_o,
    output logic            mdc_o,
    output logic            mdo_o,
    output logic            oe_o,
    output logic            done_o,
    output logic            err_o,
    output logic [15:0]     rdata_o
);
    import mdio_pkg::*;

    localparam int BIT_W   = $clog2(PRE_LEN + 36);
    localparam int LAST_WR = PRE_LEN + 31;
    localparam int LAST_RD = PRE_LEN + 34;
    localparam int DRV_RD  = 14;
    localparam int DAT_LO  = 16;
    localparam int DAT_HI  = 32;

    typedef struct packed {
        logic               run;
        logic               wr;
        logic               ext;
        logic [FRAME_W-1:0] frame;
        logic [BIT_W-1:0]   bitn;
        logic [DATA_W-1:0]  rdata;
        logic               done;
        logic               err;
    } seq_t;

    seq_t seq_q, seq_d;

    logic             phase, end_low, end_high;
    logic             in_pre, drive, in_data, samp_pt, ready;
    logic [BIT_W-1:0] pos, last_bit;

    mdio_phase_timer #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (seq_q.run),
        .phase_o    (phase),
        .end_low_o  (end_low),
        .end_high_o (end_high)
    );

    assign in_pre   = seq_q.bitn < BIT_W'(PRE_LEN);
    assign pos      = seq_q.bitn - BIT_W'(PRE_LEN);
    assign last_bit = BIT_W'(seq_q.wr ? LAST_WR : LAST_RD);
    assign drive    = seq_q.run & ~in_pre & (seq_q.wr | (pos < BIT_W'(DRV_RD)));
    assign in_data  = seq_q.run & ~seq_q.wr & ~in_pre &
                      (pos >= BIT_W'(DAT_LO)) & (pos < BIT_W'(DAT_HI));
    assign samp_pt  = seq_q.ext ? end_low : end_high;
    assign ready    = ~seq_q.run & ~block_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        if (seq_q.run) begin
            if (samp_pt && in_data) begin
                seq_d.rdata = {seq_q.rdata[DATA_W-2:0], mdi_i};
            end
            if (end_high) begin
                if (!in_pre) begin
                    seq_d.frame = seq_q.frame << 1;
                end
                if (seq_q.bitn == last_bit) begin
                    seq_d.run  = 1'b0;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.bitn = seq_q.bitn + 1'b1;
                end
            end
        end else if (req_valid_i && ready) begin
            if (sel_i == PSEL_NONE) begin
                seq_d.done = 1'b1;
                seq_d.err  = 1'b1;
            end else begin
                seq_d.run   = 1'b1;
                seq_d.wr    = req_write_i;
                seq_d.ext   = (sel_i == PSEL_EXT);
                seq_d.frame = build_frame(req_write_i,
                                          (sel_i == PSEL_EXT) ? PHY_ADDR_EXT : PHY_ADDR_INT,
                                          req_reg_i, req_wdata_i);
                seq_d.bitn  = '0;
                seq_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.run   <= 1'b0;
            seq_q.wr    <= 1'b0;
            seq_q.ext   <= 1'b0;
            seq_q.frame <= '0;
            seq_q.bitn  <= '0;
            seq_q.rdata <= '0;
            seq_q.done  <= 1'b0;
            seq_q.err   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready_o = ready;
    assign busy_o      = seq_q.run;
    assign use_ext_o   = seq_q.ext;
    assign mdc_o       = seq_q.run & phase;
    assign oe_o        = drive;
    assign mdo_o       = drive ? seq_q.frame[FRAME_W-1] : 1'b1;
    assign done_o      = seq_q.done;
    assign err_o       = seq_q.err;
    assign rdata_o     = seq_q.rdata;

    // R4: data is set up before the clock rises and does not move on the rise
    assert_data_steady_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> $stable(mdo_o));
    // R9: the end of every frame produces the completion pulse
    assert_frame_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.run) |-> (done_o && !err_o));
    // R10: while a frame runs no further request is taken
    assert_no_take_while_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && !end_high) |=> seq_q.run);

endmodule

// File: rtl/mdio_dual_eng.sv
module mdio_dual_eng #(
    parameter int         PRE_LEN      = 32,
    parameter int         HALF_CYC     = 4,
    parameter int         SETTLE_CYC   = 4,
    parameter logic [4:0] PHY_ADDR_INT = 5'h01,
    parameter logic [4:0] PHY_ADDR_EXT = 5'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        det_start_i,
    output logic        det_busy_o,
    output logic [1:0]  port_sel_o,
    output logic        det_err_o,
    output logic        port_en_int_o,
    output logic        port_en_ext_o,
    input  logic        sense_int_i,
    input  logic        sense_ext_i,
    input  logic        req_valid_i,
    output logic        req_ready_o,
    input  logic        req_write_i,
    input  logic [4:0]  req_reg_i,
    input  logic [15:0] req_wdata_i,
    output logic        done_o,
    output logic        err_o,
    output logic [15:0] rdata_o,
    output logic        mdc_int_o,
    output logic        mdo_int_o,
    output logic        mdoe_int_o,
    input  logic        mdi_int_i,
    output logic        mdc_ext_o,
    output logic        mdo_ext_o,
    output logic        mdoe_ext_o,
    input  logic        mdi_ext_i
);
    import mdio_pkg::*;

    psel_e sel;
    logic  det_busy, frame_busy, use_ext;
    logic  mdc, mdo, oe, mdi;

    mdio_port_detect #(.SETTLE_CYC(SETTLE_CYC)) detect_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (det_start_i),
        .allow_i     (~frame_busy),
        .sense_int_i (sense_int_i),
        .sense_ext_i (sense_ext_i),
        .en_int_o    (port_en_int_o),
        .en_ext_o    (port_en_ext_o),
        .busy_o      (det_busy),
        .sel_o       (sel),
        .err_o       (det_err_o)
    );

    assign mdi = use_ext ? mdi_ext_i : mdi_int_i;

    mdio_frame_seq #(
        .PRE_LEN      (PRE_LEN),
        .HALF_CYC     (HALF_CYC),
        .PHY_ADDR_INT (PHY_ADDR_INT),
        .PHY_ADDR_EXT (PHY_ADDR_EXT)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_reg_i   (req_reg_i),
        .req_wdata_i (req_wdata_i),
        .block_i     (det_busy),
        .sel_i       (sel),
        .mdi_i       (mdi),
        .req_ready_o (req_ready_o),
        .busy_o      (frame_busy),
        .use_ext_o   (use_ext),
        .mdc_o       (mdc),
        .mdo_o       (mdo),
        .oe_o        (oe),
        .done_o      (done_o),
        .err_o       (err_o),
        .rdata_o     (rdata_o)
    );

    assign det_busy_o = det_busy;
    assign port_sel_o = sel;

    assign mdc_int_o  = mdc & ~use_ext;
    assign mdoe_int_o = oe & ~use_ext;
    assign mdo_int_o  = use_ext ? 1'b1 : mdo;
    assign mdc_ext_o  = mdc & use_ext;
    assign mdoe_ext_o = oe & use_ext;
    assign mdo_ext_o  = use_ext ? mdo : 1'b1;

    // R11: a request with no port completes with an error on the next cycle
    assert_noport_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && sel == PSEL_NONE) |=> (done_o && err_o));
    // R12: with the internal port selected the external lines stay quiet
    assert_ext_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PSEL_INT && !det_busy) |-> (!mdc_ext_o && !mdoe_ext_o));
    // R12: with the external port selected the internal lines stay quiet
    assert_int_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == PSEL_EXT && !det_busy) |-> (!mdc_int_o && !mdoe_int_o));

endmodule

// File: tb/mdio_dual_eng_tb_top.sv
`timescale 1ns/1ps
module mdio_dual_eng_tb_top;

    localparam int         PRE  = 4;
    localparam int         HALF = 2;
    localparam int         SET  = 3;
    localparam logic [4:0] PA_I = 5'h05;
    localparam logic [4:0] PA_E = 5'h1A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        det_start = 1'b0, det_busy_o, det_err_o, port_en_int_o, port_en_ext_o;
    logic [1:0]  port_sel_o;
    logic        sense_int_i, sense_ext_i;
    logic        req_valid = 1'b0, req_ready_o, req_write = 1'b0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        done_o, err_o;
    logic [15:0] rdata_o;
    logic        mdc_int_o, mdo_int_o, mdoe_int_o, mdi_int_i;
    logic        mdc_ext_o, mdo_ext_o, mdoe_ext_o, mdi_ext_i;

    logic        int_present = 1'b0, ext_present = 1'b0;
    logic [63:0] seed = '0;
    int          rises = 0;
    logic [63:0] rec_d = '0, rec_oe = '0;
    logic        cur_ext = 1'b0;
    int          mon_mode = 0;
    int          idle_bad = 0;
    int          checks = 0, fails = 0;
    int          lat = 0;
    bit          finished = 0;

    assign sense_int_i = port_en_int_o & int_present;
    assign sense_ext_i = port_en_ext_o & ext_present;
    assign mdi_int_i   = seed[rises[5:0]];
    assign mdi_ext_i   = seed[rises[5:0]];

    wire mdc_act = mdc_int_o | mdc_ext_o;

    mdio_dual_eng #(
        .PRE_LEN(PRE), .HALF_CYC(HALF), .SETTLE_CYC(SET),
        .PHY_ADDR_INT(PA_I), .PHY_ADDR_EXT(PA_E)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .det_start_i(det_start), .det_busy_o(det_busy_o), .port_sel_o(port_sel_o),
        .det_err_o(det_err_o), .port_en_int_o(port_en_int_o), .port_en_ext_o(port_en_ext_o),
        .sense_int_i(sense_int_i), .sense_ext_i(sense_ext_i),
        .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
        .req_reg_i(req_reg), .req_wdata_i(req_wdata),
        .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
        .mdc_int_o(mdc_int_o), .mdo_int_o(mdo_int_o), .mdoe_int_o(mdoe_int_o), .mdi_int_i(mdi_int_i),
        .mdc_ext_o(mdc_ext_o), .mdo_ext_o(mdo_ext_o), .mdoe_ext_o(mdoe_ext_o), .mdi_ext_i(mdi_ext_i)
    );

    // PHY model: record every driven bit at the clock rise, advance read data.
    always @(posedge mdc_act) begin
        rec_d  = {rec_d[62:0],  cur_ext ? mdo_ext_o  : mdo_int_o};
        rec_oe = {rec_oe[62:0], cur_ext ? mdoe_ext_o : mdoe_int_o};
        rises  = rises + 1;
    end

    // Idle monitor for the port not in use (R12).
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_mode != 2 && (mdc_ext_o || mdoe_ext_o || !mdo_ext_o)) idle_bad++;
            if (mon_mode != 1 && (mdc_int_o || mdoe_int_o || !mdo_int_o)) idle_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic start_req(input bit wr, input logic [4:0] rg, input logic [15:0] wd);
        req_valid = 1'b1;
        req_write = wr;
        req_reg   = rg;
        req_wdata = wd;
    endtask

    task automatic wait_accept();
        bit acc;
        do begin
            acc = req_ready_o;
            @(negedge clk);
        end while (!acc);
        req_valid = 1'b0;
        rises  = 0;
        rec_d  = '0;
        rec_oe = '0;
        lat    = 1;
    endtask

    task automatic wait_done(output logic [15:0] rd, output bit e, output bit busy_ok);
        busy_ok = 1'b1;
        while (!done_o) begin
            if (req_ready_o) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd = rdata_o;
        e  = err_o;
    endtask

    task automatic check_frame(input bit wr, input logic [4:0] rg, input logic [15:0] wd,
                               input logic [15:0] rd, input bit e);
        int          bits;
        logic [31:0] frame;
        logic [4:0]  pa;
        logic [63:0] exp_d, exp_oe, pre_ones;
        logic [15:0] exp_rd;
        bits     = PRE + (wr ? 32 : 35);
        pa       = cur_ext ? PA_E : PA_I;
        frame    = {2'b01, (wr ? 2'b01 : 2'b10), pa, rg, 2'b10, (wr ? wd : 16'h0)};
        pre_ones = (64'd1 << PRE) - 64'd1;
        if (wr) begin
            exp_d  = (pre_ones << 32) | {32'h0, frame};
            exp_oe = 64'h0000_0000_FFFF_FFFF;
        end else begin
            exp_d  = (((pre_ones << 14) | {50'h0, frame[31:18]}) << 21) | ((64'd1 << 21) - 64'd1);
            exp_oe = ((64'd1 << 14) - 64'd1) << 21;
        end
        chk(lat == bits * 2 * HALF + 1, "R9", "done latency", lat, bits * 2 * HALF + 1);
        chk(e == 1'b0, "R9", "err on good frame", e, 0);
        chk(rises == bits, "R9", "clock pulses", rises, bits);
        chk(((rec_d >> (bits - PRE)) & pre_ones) == pre_ones && ((rec_oe >> (bits - PRE)) & pre_ones) == 0,
            "R3", "preamble", rec_d >> (bits - PRE), pre_ones);
        if (wr) chk(rec_d == exp_d && rec_oe == exp_oe, "R4", "write stream", rec_d, exp_d);
        else    chk(rec_d == exp_d && rec_oe == exp_oe, "R5", "read stream", rec_d, exp_d);
        chk(rec_d[bits-PRE-5 -: 5] == pa, "R8", "phy address", rec_d[bits-PRE-5 -: 5], pa);
        if (!wr) begin
            for (int k = 0; k < 16; k++) exp_rd[15-k] = seed[PRE + 16 + k + (cur_ext ? 0 : 1)];
            if (cur_ext) chk(rd == exp_rd, "R6", "ext read data", rd, exp_rd);
            else         chk(rd == exp_rd, "R7", "int read data", rd, exp_rd);
        end
        chk(idle_bad == 0, "R12", "unused port idle", idle_bad, 0);
    endtask

    task automatic do_txn(input bit wr, input logic [4:0] rg, input logic [15:0] wd,
                          input logic [63:0] sv);
        logic [15:0] rd;
        bit          e, bok;
        seed = sv;
        start_req(wr, rg, wd);
        wait_accept();
        wait_done(rd, e, bok);
        chk(bok, "R10", "ready low during frame", 0, 1);
        check_frame(wr, rg, wd, rd, e);
    endtask

    task automatic do_detect(input bit ip, input bit ep, input logic [1:0] exp_sel,
                             input bit exp_err);
        int en_cyc;
        bit rdy_ok;
        int_present = ip;
        ext_present = ep;
        det_start = 1'b1;
        @(negedge clk);
        det_start = 1'b0;
        en_cyc = 0;
        rdy_ok = 1'b1;
        while (port_en_int_o && port_en_ext_o) begin
            en_cyc++;
            if (req_ready_o) rdy_ok = 1'b0;
            @(negedge clk);
        end
        chk(en_cyc == SET, "R2", "probe length", en_cyc, SET);
        chk(port_sel_o == exp_sel, "R2", "selected port", port_sel_o, exp_sel);
        chk(det_err_o == exp_err, "R2", "probe error", det_err_o, exp_err);
        chk(rdy_ok, "R10", "ready low during probe", 0, 1);
        cur_ext  = (exp_sel == 2'd2);
        mon_mode = exp_sel;
    endtask

    task automatic noport_req();
        logic [15:0] rd;
        bit          e, bok;
        start_req(1'b1, 5'd3, 16'hBEEF);
        wait_accept();
        wait_done(rd, e, bok);
        chk(lat == 1 && e == 1'b1, "R11", "immediate error", {lat, 31'(e)}, {32'd1, 31'd1});
        repeat (6) @(negedge clk);
        chk(rises == 0, "R11", "no clock pulses", rises, 0);
    endtask

    task automatic sweep_port();
        for (int rg = 0; rg < 32; rg++) begin
            do_txn(1'b1, 5'(rg), 16'(16'h1234 * (rg + 1)) ^ 16'hC0DE, 64'h0);
            do_txn(1'b0, 5'(rg), 16'h0, 64'hD1B5_4A32_D192_ED03 * 64'(rg + 7));
        end
    endtask

    task automatic back_to_back();
        logic [15:0] rd;
        bit          e, bok;
        seed = 64'h0F1E_2D3C_4B5A_6978;
        start_req(1'b1, 5'd9, 16'h5A5A);
        wait_accept();
        start_req(1'b0, 5'd17, 16'h0);
        wait_done(rd, e, bok);
        chk(bok, "R10", "ready low with request held", 0, 1);
        check_frame(1'b1, 5'd9, 16'h5A5A, rd, e);
        wait_accept();
        wait_done(rd, e, bok);
        check_frame(1'b0, 5'd17, 16'h0, rd, e);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready_o && port_sel_o == 2'd0 && !det_err_o && !done_o, "R1", "control reset",
            {req_ready_o, port_sel_o, det_err_o, done_o}, 5'b10000);
        chk(!mdc_int_o && !mdc_ext_o && !mdoe_int_o && !mdoe_ext_o && mdo_int_o && mdo_ext_o
            && !port_en_int_o && !port_en_ext_o, "R1", "line reset",
            {mdc_int_o, mdc_ext_o, mdoe_int_o, mdoe_ext_o, mdo_int_o, mdo_ext_o}, 6'b000011);
        noport_req();
        do_detect(1'b0, 1'b0, 2'd0, 1'b1);
        noport_req();
        do_detect(1'b1, 1'b0, 2'd1, 1'b0);
        sweep_port();
        back_to_back();
        do_detect(1'b1, 1'b1, 2'd2, 1'b0);
        sweep_port();
        back_to_back();
        do_detect(1'b0, 1'b1, 2'd2, 1'b0);
        do_txn(1'b0, 5'd31, 16'h0, 64'hAAAA_5555_F0F0_0F0F);
        do_detect(1'b1, 1'b0, 2'd1, 1'b0);
        do_txn(1'b0, 5'd0, 16'h0, 64'hAAAA_5555_F0F0_0F0F);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule